// File: doc/BRIEF.md
# Row Diagnosis Marking Engine

This block works out which blocks in one row are healthy from a set of pairwise comparison results. A row holds N blocks under test. Between each neighbouring pair sits a comparator that reads 0 when the two blocks agree and 1 when they differ. When a start pulse arrives, the engine captures the comparator vector and sets every block to unknown. It then runs marking passes, one per clock. Each pass uses rules that carry a known-good verdict across to a neighbour. Passes stop when a pass changes nothing, or when N passes have run. The engine then pulses done.

With done it presents two flags. The first reports an inconsistency: the final marks contradict a comparator result, which points at a faulty comparator or at faulty routing. The second reports a unique diagnosis: no block is left unknown. The per-block verdicts stay on the status output until the next accepted start. A controller reads them after done and moves on to the next row.

Top module: `row_diag_engine`

## Requirements
- R1: After reset every status field is 00, and done, the inconsistency flag and the unique flag are all 0.
- R2: A start seen while the engine is idle captures cmp_in. On the next cycle every status field reads 00 (unknown), and done and both flags read 0. Bit k of cmp_in is the comparator between block k and block k+1. The status of block k sits at blk_status[2k+1:2k], coded 00 unknown, 01 good, 10 bad.
- R3: In a pass, an unknown interior block whose two comparators both read 0 becomes good (01).
- R4: In a pass, an unknown block becomes good when a neighbour was good at the start of the pass and the comparator between the two reads 0.
- R5: In a pass, an unknown block becomes bad (10) when a neighbour was good and the comparator between them reads 1. If R3 or R4 also applies to the block, good takes precedence. A bad block causes no change in its neighbours.
- R6: A block marked good or bad keeps its mark until the next accepted start. The code 11 never appears.
- R7: Exactly one pass runs per clock. The run ends after the first pass that changes nothing, or after the Nth pass. Done is high for exactly one cycle, the cycle after the last pass.
- R8: With done, inconsistent is 1 if any comparator reads 1 while both its blocks are good, or reads 0 while one of its blocks is good and the other bad. The flag holds its value until the next accepted start.
- R9: With done, unique_diag is 1 exactly when no block is unknown. The flag holds its value until the next accepted start.
- R10: A start that arrives while passes are running is ignored. The run in progress finishes with the comparator vector it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin diagnosing the row on cmp_in |
| cmp_in | input | N_BLK-1 | Comparator results, bit k between block k and k+1 |
| blk_status | output | 2*N_BLK | Per-block verdict, block k at [2k+1:2k] |
| done | output | 1 | One-cycle strobe after the final pass |
| inconsistent | output | 1 | Marks contradict a comparator result |
| unique_diag | output | 1 | Every block is marked good or bad |

## Verification
A wrong mark shows on blk_status in the same cycle as the pass that made it, because the status register drives the port directly. A reference model that steps one pass per clock therefore catches it at that edge. The error usually spreads after that, since later passes propagate from the wrong mark. A fault in the pass counter or the stop test shows on done: the strobe comes early, comes late or repeats, and the bench sees this on the first mismatching cycle. The flag outputs are checked against the model on every cycle, so a wrong flag is caught on the done cycle itself, and a flag that fails to hold is caught on the cycle it moves.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

   // per-block verdict code; 2'b11 is never produced
   typedef enum logic [1:0] {
      BLK_UNKNOWN = 2'b00,
      BLK_GOOD    = 2'b01,
      BLK_BAD     = 2'b10
   } blk_state_e;

   localparam int unsigned ST_W = 2;

endpackage

// File: rtl/rdm_pass.sv
// One marking pass, evaluated for all blocks in parallel from the
// verdicts held at the start of the pass.
module rdm_pass
   import rdm_pkg::*;
#(
   parameter int unsigned N_BLK = 6
) (
   input  logic [N_BLK*ST_W-1:0] cur_st,
   input  logic [N_BLK-2:0]      cmp,
   output logic [N_BLK*ST_W-1:0] nxt_st,
   output logic                  changed
);

   generate
      if (N_BLK < 2) begin : g_bad_n
         $error("rdm_pass: N_BLK must be at least 2");
      end
   endgenerate

   genvar k;
   generate
      for (k = 0; k < N_BLK; k++) begin : g_blk
         logic left_good, left_res, right_good, right_res, seed;
         logic to_good, to_bad;
         logic [ST_W-1:0] here;

         assign here = cur_st[k*ST_W +: ST_W];

         if (k == 0) begin : g_no_left
            assign left_good = 1'b0;
            assign left_res  = 1'b0;
         end else begin : g_left
            assign left_good = (cur_st[(k-1)*ST_W +: ST_W] == BLK_GOOD);
            assign left_res  = cmp[k-1];
         end

         if (k == N_BLK-1) begin : g_no_right
            assign right_good = 1'b0;
            assign right_res  = 1'b0;
         end else begin : g_right
            assign right_good = (cur_st[(k+1)*ST_W +: ST_W] == BLK_GOOD);
            assign right_res  = cmp[k];
         end

         if (k > 0 && k < N_BLK-1) begin : g_interior
            assign seed = !cmp[k-1] && !cmp[k];
         end else begin : g_edge
            assign seed = 1'b0;
         end

         assign to_good = seed
                        | (left_good  & !left_res)
                        | (right_good & !right_res);
         assign to_bad  = (left_good  & left_res)
                        | (right_good & right_res);

         always_comb begin
            if (here != BLK_UNKNOWN)
               nxt_st[k*ST_W +: ST_W] = here;
            else if (to_good)
               nxt_st[k*ST_W +: ST_W] = BLK_GOOD;
            else if (to_bad)
               nxt_st[k*ST_W +: ST_W] = BLK_BAD;
            else
               nxt_st[k*ST_W +: ST_W] = BLK_UNKNOWN;
         end
      end
   endgenerate

   assign changed = (nxt_st != cur_st);

endmodule

// File: rtl/rdm_judge.sv
// Flag evaluation over a set of verdicts and the captured comparators.
module rdm_judge
   import rdm_pkg::*;
#(
   parameter int unsigned N_BLK = 6
) (
   input  logic [N_BLK*ST_W-1:0] st,
   input  logic [N_BLK-2:0]      cmp,
   output logic                  incons,
   output logic                  all_marked
);

   logic [N_BLK-2:0] clash;
   logic [N_BLK-1:0] marked;

   genvar k;
   generate
      for (k = 0; k < N_BLK-1; k++) begin : g_cmp
         logic [ST_W-1:0] a, b;
         logic both_good, split;
         assign a = st[k*ST_W +: ST_W];
         assign b = st[(k+1)*ST_W +: ST_W];
         assign both_good = (a == BLK_GOOD) && (b == BLK_GOOD);
         assign split     = ((a == BLK_GOOD) && (b == BLK_BAD))
                         || ((a == BLK_BAD)  && (b == BLK_GOOD));
         assign clash[k]  = cmp[k] ? both_good : split;
      end
      for (k = 0; k < N_BLK; k++) begin : g_mark
         assign marked[k] = (st[k*ST_W +: ST_W] != BLK_UNKNOWN);
      end
   endgenerate

   assign incons     = |clash;
   assign all_marked = &marked;

endmodule

// File: rtl/rdm_seq.sv
// Run control: accepts start, counts passes, decides the final pass.
module rdm_seq #(
   parameter int unsigned N_BLK = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic                          changed,
   output logic                          busy,
   output logic                          load,
   output logic                          step,
   output logic                          fin,
   output logic                          done,
   output logic [$clog2(N_BLK+1)-1:0]    pass_cnt
);

   localparam int unsigned PW = $clog2(N_BLK + 1);
   localparam logic [PW-1:0] LAST_PASS = PW'(N_BLK - 1);

   logic          run_q;
   logic          done_q;
   logic [PW-1:0] pass_q;

   assign load = start && !run_q;
   assign step = run_q;
   assign fin  = run_q && (!changed || (pass_q == LAST_PASS));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         done_q <= 1'b0;
         pass_q <= '0;
      end else begin
         done_q <= fin;
         if (load) begin
            run_q  <= 1'b1;
            pass_q <= '0;
         end else if (run_q) begin
            pass_q <= pass_q + 1'b1;
            if (fin)
               run_q <= 1'b0;
         end
      end
   end

   assign busy     = run_q;
   assign done     = done_q;
   assign pass_cnt = pass_q;

endmodule

// File: rtl/row_diag_engine.sv
module row_diag_engine
   import rdm_pkg::*;
#(
   parameter int unsigned N_BLK = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [N_BLK-2:0]       cmp_in,
   output logic [2*N_BLK-1:0]     blk_status,
   output logic                   done,
   output logic                   inconsistent,
   output logic                   unique_diag
);

   localparam int unsigned SW = N_BLK * ST_W;
   localparam int unsigned PW = $clog2(N_BLK + 1);

   generate
      if (N_BLK < 2) begin : g_bad_n
         $error("row_diag_engine: N_BLK must be at least 2");
      end
   endgenerate

   logic [N_BLK-2:0] cmp_q;
   logic [SW-1:0]    st_q;
   logic [SW-1:0]    st_nxt;
   logic             changed;
   logic             busy, load, step, fin;
   logic [PW-1:0]    pass_cnt;
   logic             inc_nxt, all_nxt;
   logic             inc_q, uni_q;

   rdm_pass #(.N_BLK(N_BLK)) u_pass (
      .cur_st  (st_q),
      .cmp     (cmp_q),
      .nxt_st  (st_nxt),
      .changed (changed)
   );

   rdm_judge #(.N_BLK(N_BLK)) u_judge (
      .st         (st_nxt),
      .cmp        (cmp_q),
      .incons     (inc_nxt),
      .all_marked (all_nxt)
   );

   rdm_seq #(.N_BLK(N_BLK)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .changed  (changed),
      .busy     (busy),
      .load     (load),
      .step     (step),
      .fin      (fin),
      .done     (done),
      .pass_cnt (pass_cnt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= '0;
         st_q  <= '0;
         inc_q <= 1'b0;
         uni_q <= 1'b0;
      end else if (load) begin
         cmp_q <= cmp_in;
         st_q  <= '0;
         inc_q <= 1'b0;
         uni_q <= 1'b0;
      end else if (step) begin
         st_q <= st_nxt;
         if (fin) begin
            inc_q <= inc_nxt;
            uni_q <= all_nxt;
         end
      end
   end

   assign blk_status   = st_q;
   assign inconsistent = inc_q;
   assign unique_diag  = uni_q;

endmodule

// File: rtl/rdm_checker.sv
module rdm_checker #(
   parameter int unsigned N_BLK = 6
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       start,
   input logic [2*N_BLK-1:0]         blk_status,
   input logic                       done,
   input logic                       inconsistent,
   input logic                       unique_diag,
   input logic                       busy,
   input logic [$clog2(N_BLK+1)-1:0] pass_cnt
);

   logic has11, has00;
   always_comb begin
      has11 = 1'b0;
      has00 = 1'b0;
      for (int k = 0; k < N_BLK; k++) begin
         if (blk_status[2*k +: 2] == 2'b11) has11 = 1'b1;
         if (blk_status[2*k +: 2] == 2'b00) has00 = 1'b1;
      end
   end

   p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (blk_status == '0 && !done && !inconsistent && !unique_diag));

   p_no_code11_r6: assert property (@(posedge clk) disable iff (!rst_n) !has11);

   genvar k;
   generate
      for (k = 0; k < N_BLK; k++) begin : g_sticky
         p_mark_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(start && !busy) && $past(blk_status[2*k +: 2]) != 2'b00)
               |-> blk_status[2*k +: 2] == $past(blk_status[2*k +: 2]));
      end
   endgenerate

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

   p_pass_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pass_cnt <= ($clog2(N_BLK+1))'(N_BLK));

   p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(start && !busy) && !done) |-> ($stable(inconsistent) && $stable(unique_diag)));

   p_unique_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (unique_diag == !has00));

endmodule

bind row_diag_engine rdm_checker #(.N_BLK(N_BLK)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .blk_status   (blk_status),
   .done         (done),
   .inconsistent (inconsistent),
   .unique_diag  (unique_diag),
   .busy         (busy),
   .pass_cnt     (pass_cnt)
);

// File: tb/sim_row_diag_engine.sv
`timescale 1ns/1ps
module sim_row_diag_engine;

   localparam int N = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [N-2:0]     cmp_in = '0;
   logic [2*N-1:0]   blk_status;
   logic             done, inconsistent, unique_diag;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   row_diag_engine #(.N_BLK(N)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
      .blk_status(blk_status), .done(done),
      .inconsistent(inconsistent), .unique_diag(unique_diag)
   );

   // behavioural reference: 0 unknown, 1 good, 2 bad
   int m_st[N];
   int m_cmp[N-1];
   bit m_run, m_done, m_inc, m_uni;
   int m_pass;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < N; k++) m_st[k] = 0;
         for (int k = 0; k < N-1; k++) m_cmp[k] = 0;
         m_run = 0; m_done = 0; m_inc = 0; m_uni = 0; m_pass = 0;
      end else begin
         m_done = 0;
         if (m_run) begin
            int nx[N];
            bit chg;
            chg = 0;
            for (int k = 0; k < N; k++) begin
               bit g, b;
               g = 0; b = 0;
               if (k > 0 && k < N-1)
                  if (m_cmp[k-1] == 0 && m_cmp[k] == 0) g = 1;
               if (k > 0)
                  if (m_st[k-1] == 1) begin
                     if (m_cmp[k-1] == 0) g = 1; else b = 1;
                  end
               if (k < N-1)
                  if (m_st[k+1] == 1) begin
                     if (m_cmp[k] == 0) g = 1; else b = 1;
                  end
               if (m_st[k] != 0) nx[k] = m_st[k];
               else if (g) nx[k] = 1;
               else if (b) nx[k] = 2;
               else nx[k] = 0;
               if (nx[k] != m_st[k]) chg = 1;
            end
            for (int k = 0; k < N; k++) m_st[k] = nx[k];
            m_pass++;
            if (!chg || m_pass == N) begin
               m_run = 0;
               m_done = 1;
               m_inc = 0;
               m_uni = 1;
               for (int k = 0; k < N; k++) if (m_st[k] == 0) m_uni = 0;
               for (int k = 0; k < N-1; k++) begin
                  if (m_cmp[k] == 1 && m_st[k] == 1 && m_st[k+1] == 1) m_inc = 1;
                  if (m_cmp[k] == 0 && ((m_st[k] == 1 && m_st[k+1] == 2) ||
                                        (m_st[k] == 2 && m_st[k+1] == 1))) m_inc = 1;
               end
            end
         end else if (start) begin
            for (int k = 0; k < N-1; k++) m_cmp[k] = int'(cmp_in[k]);
            for (int k = 0; k < N; k++) m_st[k] = 0;
            m_run = 1; m_pass = 0; m_inc = 0; m_uni = 0;
         end
      end
   end

   function automatic logic [2*N-1:0] model_vec();
      logic [2*N-1:0] v;
      for (int k = 0; k < N; k++) v[2*k +: 2] = 2'(m_st[k]);
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison with the model
   always @(negedge clk) begin
      if (rst_n) begin
         logic [2*N-1:0] ev;
         bit any11;
         ev = model_vec();
         any11 = 0;
         for (int k = 0; k < N; k++) if (blk_status[2*k +: 2] == 2'b11) any11 = 1;
         chk(blk_status == ev, "R3/R4/R5", "status", int'(blk_status), int'(ev));
         chk(!any11, "R6", "code 11 seen", int'(blk_status), 0);
         chk(done == m_done, "R7", "done", int'(done), int'(m_done));
         chk(inconsistent == m_inc, "R8", "inconsistent", int'(inconsistent), int'(m_inc));
         chk(unique_diag == m_uni, "R9", "unique", int'(unique_diag), int'(m_uni));
      end
   end

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL R7 watchdog expired: actual=%0d expected<150000", cyc);
         report();
         $finish;
      end
   end

   task automatic run_row(input logic [N-2:0] pat, input bit poke, output int lat);
      @(negedge clk);
      cmp_in = pat;
      start  = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      chk(blk_status == '0 && !done, "R2", "cleared after start", int'(blk_status), 0);
      if (poke) begin
         // R10: a second start with other data while passes run
         start  = 1'b1;
         cmp_in = '1;
         @(negedge clk);
         lat++;
         start = 1'b0;
      end
      while (!done && lat < 50) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      int lat;
      repeat (3) @(negedge clk);
      chk(blk_status == '0 && !done && !inconsistent && !unique_diag,
          "R1", "reset state", int'(blk_status), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(blk_status == '0 && !done, "R1", "idle after reset", int'(blk_status), 0);

      // all agree: seeds then edges, three passes
      run_row('0, 0, lat);
      chk(blk_status == 12'h555, "R3", "all zero status", int'(blk_status), 'h555);
      chk(lat == 4, "R7", "all zero latency", lat, 4);
      chk(unique_diag && !inconsistent, "R9", "all zero unique", int'(unique_diag), 1);

      // all differ: nothing inferred, one pass
      run_row('1, 0, lat);
      chk(blk_status == 12'h000, "R9", "all one status", int'(blk_status), 0);
      chk(lat == 2, "R7", "all one latency", lat, 2);
      chk(!unique_diag, "R9", "all one not unique", int'(unique_diag), 0);

      // propagation to a bad block; block beyond a bad block stays unknown
      run_row(5'b11000, 0, lat);
      chk(blk_status == 12'h255, "R5", "bad marking", int'(blk_status), 'h255);
      chk(lat == 5, "R4", "four passes", lat, 5);

      run_row(5'b00111, 0, lat);
      chk(blk_status == 12'h560, "R4", "right seeded", int'(blk_status), 'h560);

      // isolated 1 between good blocks: contradiction
      run_row(5'b00100, 0, lat);
      chk(inconsistent == 1'b1, "R8", "contradiction", int'(inconsistent), 1);
      chk(blk_status == 12'h555, "R5", "good wins", int'(blk_status), 'h555);

      // start during a run is ignored
      run_row('0, 1, lat);
      chk(blk_status == 12'h555, "R10", "start ignored", int'(blk_status), 'h555);
      chk(lat == 4, "R10", "latency unchanged", lat, 4);
      @(negedge clk);
      chk(inconsistent == 1'b0 && unique_diag == 1'b1, "R8", "flags held",
          int'(unique_diag), 1);

      // every pattern against the model
      for (int p = 0; p < (1 << (N-1)); p++) begin
         run_row(p[N-2:0], 0, lat);
         chk(lat <= N + 1, "R7", "pass cap", lat, N + 1);
      end

      repeat (3) @(negedge clk);
      report();
      $finish;
   end

endmodule